// File: doc/BRIEF.md
# Priority Interrupt Controller with Claim/Complete

This block gathers up to 31 level-sensitive interrupt lines for one processor target and turns them into a single external-interrupt request. Source IDs start at 1, and ID 0 means "no source". Software sets the following through a 32-bit register read/write port:

- a 3-bit priority for each source;
- an enable bit for each source;
- one threshold for the target.

The block keeps a pending bit for each source. It picks the best pending, enabled source and raises `irq_o` when that source's priority is above the threshold.

To service an interrupt, software reads the claim/complete register. The read returns the winning ID, or 0 when no source qualifies. A nonzero claim clears that source's pending bit at the same clock edge. When service is finished, software writes the ID back to the same register. Between claim and completion, the source is locked out, so a line that stays high cannot raise a second request.

Each source has a gateway, which is a three-state machine:

- **GW_IDLE**: no request is held.
- **GW_PEND**: the pending bit is set.
- **GW_BUSY**: the source has been claimed and is waiting for completion.

The gateway moves between these states on three named transitions:

- **arm** (GW_IDLE to GW_PEND): the source line is high at a clock edge.
- **take** (GW_PEND to GW_BUSY): a claim read returns this source's ID.
- **release** (GW_BUSY to GW_PEND if the line is still high, otherwise GW_BUSY to GW_IDLE): a valid completion names this source.

All other cases keep the current state. The pending bit is set only in GW_PEND.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all of the following are zero: every priority, the enable word, the pending word and the threshold. `irq_o` is low and a claim read returns 0.
- R2: The priority of source n (1 to 31) is at byte address 4*n and holds 3 bits, taken from `wdata[2:0]`. It reads back in bits [2:0]. The address for ID 0 reads 0 and ignores writes.
- R3: A source whose priority is 0 never wins arbitration and never asserts `irq_o`.
- R4: Arbitration picks the highest priority among pending, enabled, nonzero-priority sources. On equal priority, the smaller ID wins.
- R5: The enable word is at 0x2000, with bit n enabling source n. Bit 0 always reads 0. A disabled source can still become pending, but it does not take part in arbitration.
- R6: The threshold is at 0x200000 and holds 3 bits, taken from `wdata[2:0]`. A winner whose priority is less than or equal to the threshold is masked, so `irq_o` is low and the claim returns 0.
- R7: A read of 0x200004 returns the qualifying winner's ID, or 0 if none qualifies. A nonzero claim clears that source's pending bit at the same edge.
- R8: Between claim and completion, a source's pending bit stays clear even while its line is high.
- R9: A write of ID n to 0x200004 completes source n if n is enabled, with bits [31:5] zero. The ID is not checked against the last claim. If the line is still high, pending is set again at the completing edge.
- R10: A completion that names a disabled source, ID 0 or an out-of-range value has no effect. A blocked source stays blocked.
- R11: `irq_o` is combinational from the current state. It is high exactly when some pending, enabled source has a priority strictly greater than the threshold.
- R12: The pending word at 0x1000 is read-only, with bit n set for source n. A pending bit stays set after its line drops. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 31 | Level-sensitive source lines; bit n is source ID n (range [NSRC:1]) |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_re_i | input | 1 | Register read strobe; a read of the claim address has a side effect |
| reg_addr_i | input | 22 | Byte address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address and state |
| irq_o | output | 1 | External-interrupt request to the target |

## Verification
The assertions assume the following about the block's inputs:

- `rst_n` is low at time zero.
- Read and write strobes are sampled only at rising edges.
- The address and data are stable while the strobes are high.

The bench drives every input at the falling edge, so all of these hold throughout. Random stimulus covers the following, and the bench always holds reset low for its first cycles:

- completion IDs of 0, in range and above 31;
- priority writes with upper data bits set;
- reads and writes at unmapped addresses.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int ADDR_W = 22;
    localparam int DATA_W = 32;
    localparam int PRIO_W = 3;

    localparam logic [ADDR_W-1:0] ADR_PEND  = 22'h001000;
    localparam logic [ADDR_W-1:0] ADR_EN    = 22'h002000;
    localparam logic [ADDR_W-1:0] ADR_THR   = 22'h200000;
    localparam logic [ADDR_W-1:0] ADR_CLAIM = 22'h200004;

    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_BUSY = 2'd2
    } gw_state_e;
endpackage

// File: rtl/pic_gateway.sv
module pic_gateway
    import pic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic claim_i,
    input  logic cpl_i,
    output logic pend_o
);
    gw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: if (line_i)  state_d = GW_PEND;                      // arm
            GW_PEND: if (claim_i) state_d = GW_BUSY;                      // take
            GW_BUSY: if (cpl_i)   state_d = line_i ? GW_PEND : GW_IDLE;   // release
            default:              state_d = GW_IDLE;
        endcase
    end

    always_comb pend_o = (state_q == GW_PEND);

    // R7
    claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |=> !pend_o);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GW_BUSY && !cpl_i) |=> (state_q == GW_BUSY && !pend_o));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int NSRC = 31,
    parameter int ID_W = $clog2(NSRC + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSRC:0]                 pend_i,
    input  logic [NSRC:0]                 en_i,
    input  logic [NSRC:0][PRIO_W-1:0]     prio_i,
    output logic [ID_W-1:0]               win_id_o,
    output logic [PRIO_W-1:0]             win_prio_o
);
    always_comb begin
        win_id_o   = '0;
        win_prio_o = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (pend_i[i] && en_i[i] && (prio_i[i] > win_prio_o)) begin
                win_prio_o = prio_i[i];
                win_id_o   = ID_W'(i);
            end
        end
    end

    // R3 R4 R5
    win_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id_o != '0) |-> (pend_i[win_id_o] && en_i[win_id_o] && prio_i[win_id_o] != '0));
endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int NSRC = 31,
    parameter int ID_W = $clog2(NSRC + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic                      re_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic [NSRC:0]             pend_i,
    input  logic [ID_W-1:0]           claim_id_i,
    output logic [NSRC:0][PRIO_W-1:0] prio_o,
    output logic [NSRC:0]             en_o,
    output logic [PRIO_W-1:0]         thr_o,
    output logic [DATA_W-1:0]         rdata_o,
    output logic                      claim_rd_o,
    output logic                      cpl_wr_o,
    output logic [ID_W-1:0]           cpl_id_o
);
    localparam int IDX_W = 10;

    logic [NSRC:1][PRIO_W-1:0] prio_q;
    logic [NSRC:1]             en_q;
    logic [PRIO_W-1:0]         thr_q;

    logic             prio_hit;
    logic [IDX_W-1:0] prio_idx;
    logic             prio_ok;
    logic             id_fits;

    assign prio_o = {prio_q, PRIO_W'(0)};
    assign en_o   = {en_q, 1'b0};
    assign thr_o  = thr_q;

    assign prio_hit = (addr_i[ADDR_W-1:12] == '0) && (addr_i[1:0] == 2'b00);
    assign prio_idx = addr_i[11:2];
    assign prio_ok  = prio_hit && (prio_idx >= IDX_W'(1)) && (prio_idx <= IDX_W'(NSRC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (we_i) begin
            for (int i = 1; i <= NSRC; i++) begin
                if (prio_ok && prio_idx == IDX_W'(i))
                    prio_q[i] <= wdata_i[PRIO_W-1:0];
            end
            if (addr_i == ADR_EN)  en_q  <= wdata_i[NSRC:1];
            if (addr_i == ADR_THR) thr_q <= wdata_i[PRIO_W-1:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (prio_ok)
            rdata_o[PRIO_W-1:0] = prio_o[prio_idx[ID_W-1:0]];
        else if (addr_i == ADR_PEND)
            rdata_o[NSRC:0] = pend_i;
        else if (addr_i == ADR_EN)
            rdata_o[NSRC:0] = en_o;
        else if (addr_i == ADR_THR)
            rdata_o[PRIO_W-1:0] = thr_q;
        else if (addr_i == ADR_CLAIM)
            rdata_o[ID_W-1:0] = claim_id_i;
    end

    assign claim_rd_o = re_i && (addr_i == ADR_CLAIM);
    assign cpl_id_o   = wdata_i[ID_W-1:0];
    assign id_fits    = (wdata_i[DATA_W-1:ID_W] == '0) && (cpl_id_o <= ID_W'(NSRC));
    assign cpl_wr_o   = we_i && (addr_i == ADR_CLAIM) && id_fits && en_o[cpl_id_o];

    // R10
    cpl_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_wr_o |-> (en_o[cpl_id_o] && cpl_id_o != '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NSRC = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     irq_src_i,
    input  logic              reg_we_i,
    input  logic              reg_re_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam int ID_W = $clog2(NSRC + 1);

    logic [NSRC:0]             pend;
    logic [NSRC:0]             en;
    logic [NSRC:0][PRIO_W-1:0] prio;
    logic [PRIO_W-1:0]         thr;
    logic [ID_W-1:0]           win_id;
    logic [PRIO_W-1:0]         win_prio;
    logic [ID_W-1:0]           claim_id;
    logic                      claim_rd;
    logic                      cpl_wr;
    logic [ID_W-1:0]           cpl_id;

    assign pend[0] = 1'b0;

    for (genvar g = 1; g <= NSRC; g++) begin : g_gw
        pic_gateway i_gw (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (irq_src_i[g]),
            .claim_i (claim_rd && (claim_id == ID_W'(g))),
            .cpl_i   (cpl_wr && (cpl_id == ID_W'(g))),
            .pend_o  (pend[g])
        );
    end

    pic_arbiter #(.NSRC(NSRC), .ID_W(ID_W)) i_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend),
        .en_i       (en),
        .prio_i     (prio),
        .win_id_o   (win_id),
        .win_prio_o (win_prio)
    );

    assign irq_o    = (win_prio > thr);
    assign claim_id = irq_o ? win_id : '0;

    pic_regs #(.NSRC(NSRC), .ID_W(ID_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we_i),
        .re_i       (reg_re_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .pend_i     (pend),
        .claim_id_i (claim_id),
        .prio_o     (prio),
        .en_o       (en),
        .thr_o      (thr),
        .rdata_o    (reg_rdata_o),
        .claim_rd_o (claim_rd),
        .cpl_wr_o   (cpl_wr),
        .cpl_id_o   (cpl_id)
    );

    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend & en) != '0));
endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
    localparam int N = 31;
    localparam logic [21:0] A_PEND = 22'h001000, A_EN = 22'h002000,
                            A_THR = 22'h200000, A_CLM = 22'h200004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N:1]  lines = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [21:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // model: 0 idle, 1 pending, 2 claimed
    int       m_st [0:N];
    bit [2:0] m_pr [0:N];
    bit       m_en [0:N];
    bit [2:0] m_thr;

    always #5 clk = ~clk;

    prio_irq_ctrl #(.NSRC(N)) i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_src_i(lines), .reg_we_i(we), .reg_re_i(re),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int m_win();
        int best = 0;
        bit [2:0] bp = 0;
        for (int i = 1; i <= N; i++)
            if (m_st[i] == 1 && m_en[i] && m_pr[i] > bp) begin bp = m_pr[i]; best = i; end
        return (bp > m_thr) ? best : 0;
    endfunction

    function automatic logic [31:0] m_read(input logic [21:0] a);
        logic [31:0] r = '0;
        int idx = int'(a[11:2]);
        if (a[21:12] == 0 && a[1:0] == 0) begin
            if (idx >= 1 && idx <= N) r = {29'd0, m_pr[idx]};
        end else if (a == A_PEND) begin
            for (int i = 1; i <= N; i++) r[i] = (m_st[i] == 1);
        end else if (a == A_EN) begin
            for (int i = 1; i <= N; i++) r[i] = m_en[i];
        end else if (a == A_THR) r = {29'd0, m_thr};
        else if (a == A_CLM) r = m_win();
        return r;
    endfunction

    function automatic string tag_of(input logic [21:0] a);
        if (a == A_CLM) return "R7";
        if (a == A_PEND) return "R12";
        if (a == A_EN) return "R5";
        if (a == A_THR) return "R6";
        if (a[21:12] == 0 && a[1:0] == 0) return "R2";
        return "R12";
    endfunction

    task automatic m_reset();
        for (int i = 0; i <= N; i++) begin m_st[i] = 0; m_pr[i] = 0; m_en[i] = 0; end
        m_thr = 0;
    endtask

    task automatic m_step(input int kind, input logic [21:0] a, input logic [31:0] d);
        int  wid = m_win();
        bit  clm = (kind == 1 && a == A_CLM);
        bit  cpl = (kind == 2 && a == A_CLM && d >= 1 && d <= N && m_en[d]);
        int  idx = int'(a[11:2]);
        for (int i = 1; i <= N; i++) begin
            case (m_st[i])
                0: if (lines[i]) m_st[i] = 1;
                1: if (clm && wid == i) m_st[i] = 2;
                default: if (cpl && d == i) m_st[i] = lines[i] ? 1 : 0;
            endcase
        end
        if (kind == 2) begin
            if (a[21:12] == 0 && a[1:0] == 0 && idx >= 1 && idx <= N) m_pr[idx] = d[2:0];
            if (a == A_EN) for (int i = 1; i <= N; i++) m_en[i] = d[i];
            if (a == A_THR) m_thr = d[2:0];
        end
    endtask

    // kind: 0 idle, 1 read, 2 write
    task automatic op(input int kind, input logic [21:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        re = (kind == 1); we = (kind == 2); addr = a; wdata = d;
        #1;
        if (kind == 1) chk(tag, rdata, m_read(a));
        chk("R11 irq", {31'd0, irq}, {31'd0, m_win() != 0});
        m_step(kind, a, d);
        @(posedge clk);
        #1;
        re = 1'b0; we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [21:0] a;
        logic [31:0] d;
        void'($urandom(32'd2718));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        op(1, A_CLM, 0, "R1 claim");
        op(1, A_PEND, 0, "R1 pending");
        op(1, A_EN, 0, "R1 enable");
        op(1, A_THR, 0, "R1 threshold");
        op(1, 22'h00000C, 0, "R1 prio");

        // R2 R3 R4 R5 setup: 3 and 7 tie at 5, 2 has prio 0
        op(2, 22'h00000C, 32'hFFFF_FFF5, "R2");
        op(2, 22'h00001C, 5, "R2");
        op(2, 22'h000000, 7, "R2");
        op(1, 22'h00000C, 0, "R2 readback");
        op(1, 22'h000000, 0, "R2 id0");
        op(2, A_EN, 32'h0000_008D, "R5");
        op(1, A_EN, 0, "R5 bit0");
        lines[2] = 1; lines[3] = 1; lines[7] = 1; lines[9] = 1;
        op(0, 0, 0, "");
        op(1, A_PEND, 0, "R5 R12 disabled src pends");
        op(1, A_CLM, 0, "R4 R3 tie lowest id");
        op(0, 0, 0, "");
        op(1, A_PEND, 0, "R8 blocked while claimed");
        op(2, A_PEND, 32'hFFFF_FFFF, "R12");
        op(1, A_PEND, 0, "R12 read-only");
        op(2, A_THR, 5, "R6");
        op(1, A_CLM, 0, "R6 masked at equal");
        op(2, A_THR, 4, "R6");
        op(1, A_CLM, 0, "R7 claim");
        op(2, A_CLM, 3, "R9 completion");
        op(1, A_PEND, 0, "R9 re-pend");
        op(2, A_EN, 32'h0000_000D, "R10");
        op(2, A_CLM, 7, "R10 disabled completion");
        op(2, A_CLM, 32'h0000_0027, "R10 out of range");
        op(2, A_EN, 32'h0000_008D, "R10");
        op(1, A_PEND, 0, "R10 still blocked");
        lines = '0;
        op(1, A_CLM, 0, "R7");
        op(0, 0, 0, "");
        op(1, A_PEND, 0, "R12 latched after drop");
        op(1, 22'h003000, 0, "R12 unmapped");
        op(1, 22'h200008, 0, "R12 unmapped");
        op(2, A_THR, 7, "R6");
        op(1, A_CLM, 0, "R6 thr7 masks all");
        op(2, A_THR, 0, "R6");

        for (int k = 0; k < 4000; k++) begin
            int r = $urandom_range(0, 9);
            if ($urandom_range(0, 3) == 0) lines[$urandom_range(1, N)] ^= 1'b1;
            case (r)
                0, 1: begin
                    a = 22'($urandom_range(0, 33) * 4);
                    d = ($urandom_range(0, 7) == 0) ? $urandom() : 32'($urandom_range(0, 7));
                    op(2, a, d, "R2");
                end
                2: op(2, A_EN, $urandom(), "R5");
                3: op(2, A_THR, 32'($urandom_range(0, 4)), "R6");
                4, 5: op(1, A_CLM, 0, "R7 random claim");
                6: op(2, A_CLM, 32'($urandom_range(0, 35)), "R9");
                7: begin
                    case ($urandom_range(0, 4))
                        0: a = A_PEND;
                        1: a = A_EN;
                        2: a = A_THR;
                        3: a = 22'($urandom_range(0, 40) * 4);
                        default: a = 22'($urandom());
                    endcase
                    op(1, a, 0, tag_of(a));
                end
                default: op(0, 0, 0, "");
            endcase
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule